// File: doc/BRIEF.md
# Tapped RAM Delay Line

This block is a word-wide delay line with taps that keeps its contents in small simple dual-port memories instead of a flip-flop chain. One shift-in word of `WORD_W` bits enters the line on every clock where the enable is high. The line is `TAP_GAP * TAP_CNT` words long. It exposes one tap every `TAP_GAP` words. All taps are packed into a single bus, and the word at the far end of the line is also given on its own output.

The line is split into `TAP_CNT` segments. Each segment is a `TAP_GAP`-deep memory with a registered read port, and each segment's read data feeds the next segment's write port. One circular pointer, shared by all segments, addresses every memory. When the enable is low, all state holds. A synchronous reset returns the pointer to zero and keeps the outputs at zero until the whole line holds data written after the reset. The memories themselves are never cleared.

Top module: `tapped_delay_ram`

## Requirements
- R1: After the n-th enabled clock since reset, with n > TAP_GAP*TAP_CNT, bus word k of `taps_o` (k = 0 is bits WORD_W-1..0) equals the word accepted on enabled clock n-(k+1)*TAP_GAP.
- R2: Exactly one full word is accepted per enabled clock, and this also holds with WORD_W = 1.
- R3: Taps are ordered from the far end of the line: the most significant bus word shows the oldest position. With TAP_GAP = 3, TAP_CNT = 4 and inputs 1, 2, 3, ... on consecutive enabled clocks, after the 20th input `taps_o` reads 32'h080B0E11.
- R4: `dout_o` always equals the most significant WORD_W bits of `taps_o`.
- R5: While `srst_i` is high, and for the first TAP_GAP*TAP_CNT enabled clocks after it falls, `taps_o` and `dout_o` are zero.
- R6: A clock with `ce_i` low changes neither output, whatever `din_i` carries.
- R7: A reset in the middle of a run restarts the fill, so stale memory contents never reach the outputs. After the new fill completes, R1 holds again, counting from the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Clock enable; shifts one word when high |
| din_i | input | WORD_W | Word entering the line |
| taps_o | output | WORD_W*TAP_CNT | Packed taps, oldest position in the top word |
| dout_o | output | WORD_W | Word at the far end of the line |

## Verification
The hardest case to reach is a reset that arrives while the memories are full of older data. The outputs must then stay zero through a new fill in which enables are sparse and irregular, and must never show a stale word. The bench first fills the line with a known ramp and runs a long stream of random data under random enables. It then resets in the middle of the stream and refills with bursty enables. A shift-history model predicts every tap on every clock, including the zero window. A second instance, one bit wide with a gap of two, receives the same control stimulus.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    // Smallest tap spacing the read-ahead addressing supports.
    localparam int unsigned MIN_TAP_GAP = 2;

    // Bits needed to index n entries, at least one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tdr_addr_ctrl.sv
module tdr_addr_ctrl #(
    parameter int unsigned TAP_GAP = 3,
    parameter int unsigned TAP_CNT = 4,
    localparam int unsigned AW     = tdr_pkg::idx_bits(TAP_GAP)
) (
    input  logic          clk_i,
    input  logic          srst_i,
    input  logic          ce_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          full_o
);
    localparam int unsigned DEPTH = TAP_GAP * TAP_CNT;
    localparam int unsigned CW    = tdr_pkg::idx_bits(DEPTH + 2);
    localparam logic [AW-1:0] LAST_PTR = AW'(TAP_GAP - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] fill;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i) begin
            st_d.ptr  = '0;
            st_d.fill = '0;
        end else if (ce_i) begin
            st_d.ptr = (st_q.ptr == LAST_PTR) ? '0 : st_q.ptr + AW'(1);
            if (st_q.fill != FULL_CNT) begin
                st_d.fill = st_q.fill + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Read one slot ahead of the write: that slot was written TAP_GAP-1
    // enables ago, and the read register adds the last stage of delay.
    assign wr_addr_o = st_q.ptr;
    assign rd_addr_o = (st_q.ptr == LAST_PTR) ? '0 : st_q.ptr + AW'(1);
    assign full_o    = (st_q.fill == FULL_CNT);

endmodule

// File: rtl/tdr_ram_seg.sv
module tdr_ram_seg #(
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned TAP_GAP = 3,
    localparam int unsigned AW     = tdr_pkg::idx_bits(TAP_GAP)
) (
    input  logic              clk_i,
    input  logic              srst_i,
    input  logic              ce_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [WORD_W-1:0] mem [TAP_GAP];
    logic [WORD_W-1:0] rd_d, rd_q;

    // Write port: plain storage, no reset.
    always_ff @(posedge clk_i) begin
        if (ce_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Read port: registered, advances only with the enable.
    always_comb begin
        rd_d = rd_q;
        if (srst_i) begin
            rd_d = '0;
        end else if (ce_i) begin
            rd_d = mem[rd_addr_i];
        end
    end

    always_ff @(posedge clk_i) begin
        rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/tapped_delay_ram.sv
module tapped_delay_ram #(
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned TAP_GAP = 3,
    parameter int unsigned TAP_CNT = 4
) (
    input  logic                      clk_i,
    input  logic                      srst_i,
    input  logic                      ce_i,
    input  logic [WORD_W-1:0]         din_i,
    output logic [WORD_W*TAP_CNT-1:0] taps_o,
    output logic [WORD_W-1:0]         dout_o
);
    localparam int unsigned AW = tdr_pkg::idx_bits(TAP_GAP);

    if (TAP_GAP < tdr_pkg::MIN_TAP_GAP) begin : g_bad_gap
        $error("TAP_GAP must be at least 2");
    end

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } in_t;

    in_t               in_d, in_q;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic              full;
    logic [WORD_W-1:0] seg_out [TAP_CNT];

    // Input stage: one register ahead of the first segment.
    always_comb begin
        in_d = in_q;
        if (srst_i) begin
            in_d.word = '0;
        end else if (ce_i) begin
            in_d.word = din_i;
        end
    end

    always_ff @(posedge clk_i) begin
        in_q <= in_d;
    end

    tdr_addr_ctrl #(
        .TAP_GAP (TAP_GAP),
        .TAP_CNT (TAP_CNT)
    ) u_ctrl (
        .clk_i     (clk_i),
        .srst_i    (srst_i),
        .ce_i      (ce_i),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .full_o    (full)
    );

    for (genvar k = 0; k < TAP_CNT; k++) begin : g_seg
        logic [WORD_W-1:0] seg_in;
        if (k == 0) begin : g_head
            assign seg_in = in_q.word;
        end else begin : g_link
            assign seg_in = seg_out[k-1];
        end

        tdr_ram_seg #(
            .WORD_W  (WORD_W),
            .TAP_GAP (TAP_GAP)
        ) u_seg (
            .clk_i     (clk_i),
            .srst_i    (srst_i),
            .ce_i      (ce_i),
            .wr_addr_i (wr_addr),
            .rd_addr_i (rd_addr),
            .wr_data_i (seg_in),
            .rd_data_o (seg_out[k])
        );

        // Segment k lags by (k+1)*TAP_GAP words; the oldest tap is on top.
        assign taps_o[k*WORD_W +: WORD_W] = full ? seg_out[k] : '0;
    end

    assign dout_o = full ? seg_out[TAP_CNT-1] : '0;

endmodule

// File: rtl/tapped_delay_ram_chk.sv
module tapped_delay_ram_chk #(
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned TAP_GAP = 3,
    parameter int unsigned TAP_CNT = 4,
    localparam int unsigned AW     = tdr_pkg::idx_bits(TAP_GAP)
) (
    input logic                      clk_i,
    input logic                      srst_i,
    input logic                      ce_i,
    input logic [WORD_W*TAP_CNT-1:0] taps_o,
    input logic [WORD_W-1:0]         dout_o,
    input logic [AW-1:0]             wr_addr,
    input logic [AW-1:0]             rd_addr
);
    localparam int unsigned DEPTH = TAP_GAP * TAP_CNT;
    localparam int unsigned CW    = tdr_pkg::idx_bits(DEPTH + 2);
    localparam logic [CW-1:0] SAT = CW'(DEPTH + 1);

    // Enabled clocks since reset, counted here on its own.
    logic [CW-1:0] seen;
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            seen <= '0;
        end else if (ce_i && seen != SAT) begin
            seen <= seen + CW'(1);
        end
    end

    AST_CLEAR_ON_RESET: assert property (@(posedge clk_i)
        srst_i |=> (taps_o == '0)); // R5
    AST_ZERO_UNTIL_FULL: assert property (@(posedge clk_i) disable iff (srst_i)
        (seen != SAT) |-> (taps_o == '0 && dout_o == '0)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (srst_i)
        !ce_i |=> $stable(taps_o) && $stable(dout_o)); // R6
    AST_SHIFTOUT_MSB: assert property (@(posedge clk_i) disable iff (srst_i)
        dout_o == taps_o[WORD_W*TAP_CNT-1 -: WORD_W]); // R4
    AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (srst_i)
        (32'(wr_addr) < TAP_GAP) && (32'(rd_addr) < TAP_GAP)); // R1
    AST_ADDR_DISTINCT: assert property (@(posedge clk_i) disable iff (srst_i)
        rd_addr != wr_addr); // R1

endmodule

bind tapped_delay_ram tapped_delay_ram_chk #(
    .WORD_W  (WORD_W),
    .TAP_GAP (TAP_GAP),
    .TAP_CNT (TAP_CNT)
) u_chk (
    .clk_i   (clk_i),
    .srst_i  (srst_i),
    .ce_i    (ce_i),
    .taps_o  (taps_o),
    .dout_o  (dout_o),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr)
);

// File: tb/tapped_delay_ram_tb.sv
`timescale 1ns/1ps
module tapped_delay_ram_tb;

    logic        clk  = 1'b0;
    logic        srst = 1'b1;
    logic        ce   = 1'b0;
    logic [7:0]  din  = '0;
    logic        din_n = 1'b0;
    logic [31:0] taps;
    logic [7:0]  dout;
    logic [2:0]  taps_n;
    logic        dout_n;

    int checks = 0;
    int errors = 0;
    int n      = 0;
    logic [7:0] hist [0:4095];

    always #10 clk = ~clk;

    tapped_delay_ram #(.WORD_W(8), .TAP_GAP(3), .TAP_CNT(4)) u_dut (
        .clk_i(clk), .srst_i(srst), .ce_i(ce), .din_i(din),
        .taps_o(taps), .dout_o(dout)
    );

    tapped_delay_ram #(.WORD_W(1), .TAP_GAP(2), .TAP_CNT(3)) u_dut_narrow (
        .clk_i(clk), .srst_i(srst), .ce_i(ce), .din_i(din_n),
        .taps_o(taps_n), .dout_o(dout_n)
    );

    function automatic logic [31:0] exp_wide(input int cnt);
        logic [31:0] r = '0;
        if (cnt >= 13) begin
            for (int k = 0; k < 4; k++) r[k*8 +: 8] = hist[cnt - (k+1)*3];
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_narrow(input int cnt);
        logic [2:0] r = '0;
        if (cnt >= 7) begin
            for (int k = 0; k < 3; k++) r[k] = hist[cnt - (k+1)*2][0];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (n=%0d)", tag, act, exp, n);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic [7:0] d, input string tag);
        logic [31:0] ew;
        srst = r; ce = e; din = d; din_n = d[0];
        @(posedge clk);
        @(negedge clk);
        if (r) n = 0;
        else if (e && n < 4095) begin n++; hist[n] = d; end
        ew = exp_wide(n);
        check(tag, taps, ew);
        check("R4", {24'b0, dout}, {24'b0, ew[31:24]});
        check("R2", {29'b0, taps_n}, {29'b0, exp_narrow(n)});
        check("R4", {31'b0, dout_n}, {31'b0, exp_narrow(n)[2]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        @(negedge clk);
        // R5: reset state.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'hA5, "R5");
        // Ramp fill: R5 zero window, then R1.
        for (int i = 1; i <= 20; i++) step(1'b0, 1'b1, 8'(i), (i <= 12) ? "R5" : "R1");
        check("R3", taps, 32'h080B0E11);
        check("R4", {24'b0, dout}, 32'h08);
        // Random data under random enables: R1.
        for (int i = 0; i < 2500; i++)
            step(1'b0, ($urandom % 4) != 0, 8'($urandom), "R1");
        // Enable low with changing input: R6.
        held = taps;
        for (int i = 0; i < 25; i++) step(1'b0, 1'b0, 8'($urandom), "R6");
        check("R6", taps, held);
        // Reset mid-run over stale memory, then bursty refill: R7.
        step(1'b1, 1'b1, 8'($urandom), "R7");
        step(1'b1, 1'b0, 8'($urandom), "R7");
        for (int i = 0; i < 300; i++)
            step(1'b0, ($urandom % 3) == 0, 8'($urandom), "R7");
        for (int i = 0; i < 100; i++)
            step(1'b0, 1'b1, 8'($urandom), "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule